// File: doc/BRIEF.md
# Dual-Source PDC Interrupt and Status Controller

This block keeps the "data received" state for a program-delivery-control receiver that listens to two broadcast sources at once: the teletext-carried PDC packet and the line-16 video programme signal (VPS). The line decoders upstream deliver one pulse per line and source: one when the framing and header (or start code) were valid, and one when the whole line came out with no error. The block turns these pulses into two sticky received flags, an active-low interrupt request for the host controller, and a status byte. It also reports a data-signal-quality bit and the acquisition mode the decoders should use.

A programmable error level chooses between two policies. At the strict level a flag is raised only by a fully clean line. At the relaxed level any line with valid framing raises it, so that host software can judge each nibble's error marks itself. Reading the status byte hands the flags to the host: both flags drop and the interrupt is released, unless a new event arrives in the same cycle.

The host bus interface writes the control and interrupt-enable registers through write strobes with byte-wide data. It raises a one-cycle read pulse whenever it fetches the status byte.

Top module: `pdc_irq_status`

## Requirements
- R1: After reset the status byte is 0x00, `irq_no` is 1, `acq_mode_o` is 0 (automatic), the error level is strict and both interrupt enables are 0.
- R2: At the strict level (control bit 4 = 0) a source's received flag is set only by that source's clean-line pulse. A header/start-code pulse alone leaves it unchanged.
- R3: At the relaxed level (control bit 4 = 1) a source's received flag is set by its header/start-code pulse or by its clean-line pulse.
- R4: `stat_o` bit 7 is signal quality, bit 6 is the teletext received flag, bit 5 is the VPS received flag, and bits 4..0 read 0.
- R5: `irq_no` is 0 exactly when (teletext flag AND enable bit 6) OR (VPS flag AND enable bit 5), the enables being bits 6 and 5 of the last enable-register write. Other enable bits have no effect.
- R6: A status-read pulse with no event in the same cycle clears both flags. The interrupt is released in the following cycle.
- R7: An event that sets a flag in the same cycle as a status read wins, and that flag is set afterwards. The other flag is still cleared by the read.
- R8: `acq_mode_o` decodes control bits 1..0: 01 gives 1 (VPS only), 10 gives 2 (teletext only), and 00 or 11 give 0 (automatic).
- R9: Signal quality is 1 from the cycle after any teletext header or VPS start-code pulse. It falls to 0 once `QUAL_WIN` line pulses have passed with no such pulse. It is 0 after reset.
- R10: Changes of signal quality never change `irq_no`.
- R11: Control and enable registers change only on a cycle with their write strobe high. Data presented without a strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control data: bit 4 error level, bits 1..0 acquire select |
| ien_we_i | input | 1 | Interrupt-enable register write strobe |
| ien_wdata_i | input | 8 | Enable data: bit 6 teletext, bit 5 VPS |
| ttx_hdr_ok_i | input | 1 | Teletext line with valid framing and header |
| ttx_clean_i | input | 1 | Teletext line stored free of errors |
| vps_start_ok_i | input | 1 | VPS line with valid start code |
| vps_clean_i | input | 1 | VPS line stored free of errors |
| line_i | input | 1 | One pulse per video line, used by the quality window |
| stat_rd_i | input | 1 | Status byte read pulse |
| stat_o | output | 8 | Status byte |
| irq_no | output | 1 | Interrupt request, active low |
| acq_mode_o | output | 2 | Acquisition mode for the decoders |

## Verification
The two functions that meet in one cycle are the status-read clear and a flag-setting event. There is also the quality-window advance by a line pulse against a window restart by a header pulse. The bench drives a read together with a header or clean pulse at both error levels, and a line pulse together with a start code. A behavioural reference model gives event-over-clear and restart-over-advance priority, and the design is compared against it every cycle. A long stretch of random stimulus then makes these collisions occur many more times under every enable and level setting.

// File: rtl/pdc_irq_pkg.sv
package pdc_irq_pkg;
  localparam int NUM_SRC      = 2;
  localparam int SRC_TTX      = 0;
  localparam int SRC_VPS      = 1;
  localparam int CTRL_LVL_BIT = 4;
  localparam int IEN_TTX_BIT  = 6;
  localparam int IEN_VPS_BIT  = 5;
  localparam int STAT_DSQ_BIT = 7;
  localparam int STAT_TTX_BIT = 6;
  localparam int STAT_VPS_BIT = 5;

  typedef enum logic [1:0] {
    ACQ_AUTO = 2'd0,
    ACQ_VPS  = 2'd1,
    ACQ_TTX  = 2'd2
  } acq_mode_e;

  function automatic acq_mode_e decode_acq(input logic [1:0] sel);
    case (sel)
      2'b01:   return ACQ_VPS;
      2'b10:   return ACQ_TTX;
      default: return ACQ_AUTO;
    endcase
  endfunction
endpackage

// File: rtl/pdc_cfg_regs.sv
module pdc_cfg_regs
  import pdc_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctrl_we_i,
  input  logic [7:0]         ctrl_wdata_i,
  input  logic               ien_we_i,
  input  logic [7:0]         ien_wdata_i,
  output logic               err_lvl_o,
  output logic [1:0]         acq_sel_o,
  output logic [NUM_SRC-1:0] ien_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_lvl_o <= 1'b0;
      acq_sel_o <= 2'b00;
    end else if (ctrl_we_i) begin
      err_lvl_o <= ctrl_wdata_i[CTRL_LVL_BIT];
      acq_sel_o <= ctrl_wdata_i[1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_o <= '0;
    end else if (ien_we_i) begin
      ien_o[SRC_TTX] <= ien_wdata_i[IEN_TTX_BIT];
      ien_o[SRC_VPS] <= ien_wdata_i[IEN_VPS_BIT];
    end
  end
endmodule

// File: rtl/pdc_rx_flag.sv
module pdc_rx_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_lvl_i,
  input  logic hdr_ok_i,
  input  logic clean_i,
  input  logic clr_i,
  output logic flag_o
);
  logic set;

  // relaxed level accepts any framed line; a clean line is always framed
  assign set = clean_i | (err_lvl_i & hdr_ok_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set)   flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/pdc_sig_quality.sv
module pdc_sig_quality #(
  parameter int QUAL_WIN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic seen_i,
  output logic good_o
);
  localparam int CW = $clog2(QUAL_WIN + 1);
  localparam logic [CW-1:0] LIM = CW'(QUAL_WIN);

  logic [CW-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     age_q <= LIM;
    else if (seen_i)                 age_q <= '0;
    else if (line_i && age_q != LIM) age_q <= age_q + 1'b1;
  end

  assign good_o = (age_q != LIM);
endmodule

// File: rtl/pdc_irq_status.sv
module pdc_irq_status
  import pdc_irq_pkg::*;
#(
  parameter int QUAL_WIN = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctrl_we_i,
  input  logic [7:0] ctrl_wdata_i,
  input  logic       ien_we_i,
  input  logic [7:0] ien_wdata_i,
  input  logic       ttx_hdr_ok_i,
  input  logic       ttx_clean_i,
  input  logic       vps_start_ok_i,
  input  logic       vps_clean_i,
  input  logic       line_i,
  input  logic       stat_rd_i,
  output logic [7:0] stat_o,
  output logic       irq_no,
  output logic [1:0] acq_mode_o
);
  logic               err_lvl;
  logic [1:0]         acq_sel;
  logic [NUM_SRC-1:0] ien;
  logic [NUM_SRC-1:0] hdr_ok;
  logic [NUM_SRC-1:0] clean;
  logic [NUM_SRC-1:0] flag;
  logic               dsq;

  assign hdr_ok[SRC_TTX] = ttx_hdr_ok_i;
  assign hdr_ok[SRC_VPS] = vps_start_ok_i;
  assign clean[SRC_TTX]  = ttx_clean_i;
  assign clean[SRC_VPS]  = vps_clean_i;

  pdc_cfg_regs u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_we_i   (ctrl_we_i),
    .ctrl_wdata_i(ctrl_wdata_i),
    .ien_we_i    (ien_we_i),
    .ien_wdata_i (ien_wdata_i),
    .err_lvl_o   (err_lvl),
    .acq_sel_o   (acq_sel),
    .ien_o       (ien)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    pdc_rx_flag u_flag (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .err_lvl_i(err_lvl),
      .hdr_ok_i (hdr_ok[s]),
      .clean_i  (clean[s]),
      .clr_i    (stat_rd_i),
      .flag_o   (flag[s])
    );
  end

  pdc_sig_quality #(.QUAL_WIN(QUAL_WIN)) u_qual (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .line_i(line_i),
    .seen_i(|hdr_ok),
    .good_o(dsq)
  );

  always_comb begin
    stat_o               = '0;
    stat_o[STAT_DSQ_BIT] = dsq;
    stat_o[STAT_TTX_BIT] = flag[SRC_TTX];
    stat_o[STAT_VPS_BIT] = flag[SRC_VPS];
  end

  assign irq_no     = ~|(flag & ien);
  assign acq_mode_o = decode_acq(acq_sel);
endmodule

// File: rtl/pdc_irq_status_chk.sv
module pdc_irq_status_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ctrl_we_i,
  input logic [7:0] ctrl_wdata_i,
  input logic       ttx_hdr_ok_i,
  input logic       ttx_clean_i,
  input logic       vps_start_ok_i,
  input logic       vps_clean_i,
  input logic       stat_rd_i,
  input logic [7:0] stat_o,
  input logic       irq_no,
  input logic [1:0] acq_mode_o,
  input logic       err_lvl_i
);
  a_r2_hdr_alone_ttx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_lvl_i && !stat_o[6] && !ttx_clean_i) |=> !stat_o[6]);

  a_r2_hdr_alone_vps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_lvl_i && !stat_o[5] && !vps_clean_i) |=> !stat_o[5]);

  a_r3_relaxed_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_lvl_i && ttx_hdr_ok_i) |=> stat_o[6]);

  a_r5_no_flag_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o[6:5] == 2'b00) |-> irq_no);

  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !ttx_hdr_ok_i && !ttx_clean_i && !vps_start_ok_i && !vps_clean_i)
    |=> (stat_o[6:5] == 2'b00 && irq_no));

  a_r7_event_wins_ttx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && ttx_clean_i) |=> stat_o[6]);

  a_r7_event_wins_vps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && vps_clean_i) |=> stat_o[5]);

  a_r8_ttx_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ctrl_wdata_i[1:0] == 2'b10) |=> (acq_mode_o == 2'd2));

  a_r9_quality_on_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ttx_hdr_ok_i || vps_start_ok_i) |=> stat_o[7]);
endmodule

bind pdc_irq_status pdc_irq_status_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ctrl_we_i     (ctrl_we_i),
  .ctrl_wdata_i  (ctrl_wdata_i),
  .ttx_hdr_ok_i  (ttx_hdr_ok_i),
  .ttx_clean_i   (ttx_clean_i),
  .vps_start_ok_i(vps_start_ok_i),
  .vps_clean_i   (vps_clean_i),
  .stat_rd_i     (stat_rd_i),
  .stat_o        (stat_o),
  .irq_no        (irq_no),
  .acq_mode_o    (acq_mode_o),
  .err_lvl_i     (err_lvl)
);

// File: tb/sim_pdc_irq_status.sv
module sim_pdc_irq_status;
  localparam int QW = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_we = 1'b0, ien_we = 1'b0;
  logic [7:0] ctrl_wdata = '0, ien_wdata = '0;
  logic       ttx_hdr = 1'b0, ttx_clean = 1'b0, vps_start = 1'b0, vps_clean = 1'b0;
  logic       line = 1'b0, rd = 1'b0;
  logic [7:0] stat;
  logic       irq_n;
  logic [1:0] acq;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  string tag = "R1";

  // reference model state
  bit m_lvl = 0, m_en_t = 0, m_en_v = 0, m_ft = 0, m_fv = 0;
  bit [1:0] m_acq = 0;
  int m_age = QW;

  always #2 clk = ~clk;

  pdc_irq_status #(.QUAL_WIN(QW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .ien_we_i(ien_we), .ien_wdata_i(ien_wdata),
    .ttx_hdr_ok_i(ttx_hdr), .ttx_clean_i(ttx_clean),
    .vps_start_ok_i(vps_start), .vps_clean_i(vps_clean),
    .line_i(line), .stat_rd_i(rd),
    .stat_o(stat), .irq_no(irq_n), .acq_mode_o(acq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    bit st, sv;
    st = ttx_clean || (m_lvl && ttx_hdr);
    sv = vps_clean || (m_lvl && vps_start);
    m_ft = st ? 1'b1 : (rd ? 1'b0 : m_ft);
    m_fv = sv ? 1'b1 : (rd ? 1'b0 : m_fv);
    if (ttx_hdr || vps_start) m_age = 0;
    else if (line && m_age < QW) m_age++;
    if (ctrl_we) begin
      m_lvl = ctrl_wdata[4];
      m_acq = ctrl_wdata[1:0];
    end
    if (ien_we) begin
      m_en_t = ien_wdata[6];
      m_en_v = ien_wdata[5];
    end
  endtask

  task automatic compare();
    bit [7:0] es;
    bit ei;
    int ea;
    es = {(m_age < QW), m_ft, m_fv, 5'b0};
    ei = !((m_ft && m_en_t) || (m_fv && m_en_v));
    ea = (m_acq == 2'b01) ? 1 : (m_acq == 2'b10) ? 2 : 0;
    chk(stat[7] == es[7], tag, "R9 quality", stat[7], es[7]);
    chk(stat[6:5] == es[6:5], tag, "R4 flags", stat[6:5], es[6:5]);
    chk(stat[4:0] == 5'b0, tag, "R4 spare bits", stat[4:0], 0);
    chk(irq_n == ei, tag, "R5 irq_no", irq_n, ei);
    chk(acq == ea[1:0], tag, "R8 acq_mode", acq, ea);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    ctrl_we = 0; ien_we = 0; ttx_hdr = 0; ttx_clean = 0;
    vps_start = 0; vps_clean = 0; line = 0; rd = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    compare();
    chk(stat == 8'h00 && irq_n == 1'b1, "R1", "reset status/irq", {stat, irq_n}, 9'h001);
    cyc();

    tag = "R8";
    for (int a = 0; a < 4; a++) begin
      ctrl_we = 1; ctrl_wdata = 8'(a);
      cyc();
    end
    ctrl_we = 1; ctrl_wdata = 8'h00; cyc();

    tag = "R2";
    ttx_hdr = 1; cyc();
    vps_start = 1; cyc();
    chk(stat[6:5] == 2'b00, "R2", "hdr alone at strict level", stat[6:5], 0);
    ttx_clean = 1; cyc();
    chk(stat[6] == 1'b1, "R2", "clean sets ttx flag", stat[6], 1);
    vps_clean = 1; cyc();

    tag = "R6";
    rd = 1; cyc();
    chk(stat[6:5] == 2'b00, "R6", "read clears flags", stat[6:5], 0);
    cyc();

    tag = "R5";
    ttx_clean = 1; cyc();
    chk(irq_n == 1'b1, "R5", "flag without enable", irq_n, 1);
    ien_we = 1; ien_wdata = 8'h40; cyc();
    chk(irq_n == 1'b0, "R5", "ttx enable asserts irq", irq_n, 0);
    ien_we = 1; ien_wdata = 8'h9F; cyc();
    chk(irq_n == 1'b1, "R5", "other enable bits ignored", irq_n, 1);
    ien_we = 1; ien_wdata = 8'h20; cyc();
    vps_clean = 1; cyc();
    chk(irq_n == 1'b0, "R5", "vps enable asserts irq", irq_n, 0);
    rd = 1; cyc();
    chk(irq_n == 1'b1, "R6", "read releases irq", irq_n, 1);

    tag = "R3";
    ctrl_we = 1; ctrl_wdata = 8'h10; cyc();
    ttx_hdr = 1; cyc();
    chk(stat[6] == 1'b1, "R3", "hdr sets ttx at relaxed level", stat[6], 1);
    vps_start = 1; cyc();
    chk(stat[5] == 1'b1, "R3", "start code sets vps", stat[5], 1);
    rd = 1; cyc();

    tag = "R7";
    ttx_hdr = 1; rd = 1; cyc();
    chk(stat[6] == 1'b1, "R7", "event beats read", stat[6], 1);
    vps_clean = 1; rd = 1; cyc();
    chk(stat[6:5] == 2'b01, "R7", "read clears other flag only", stat[6:5], 1);

    tag = "R9";
    rd = 1; cyc();
    for (int i = 0; i < QW; i++) begin
      line = 1; cyc();
    end
    chk(stat[7] == 1'b0, "R9", "quality drops after window", stat[7], 0);
    vps_start = 1; line = 1; cyc();
    chk(stat[7] == 1'b1, "R9", "start code with line restarts window", stat[7], 1);
    for (int i = 0; i < QW - 1; i++) begin
      line = 1; cyc();
    end
    chk(stat[7] == 1'b1, "R9", "still inside window", stat[7], 1);

    tag = "R10";
    ien_we = 1; ien_wdata = 8'h60; cyc();
    rd = 1; cyc();
    ttx_clean = 1; cyc();
    for (int i = 0; i < QW + 1; i++) begin
      line = 1; cyc();
      chk(irq_n == 1'b0, "R10", "quality change leaves irq", irq_n, 0);
    end

    tag = "R11";
    rd = 1; cyc();
    ctrl_wdata = 8'h00; ien_wdata = 8'h00; ttx_hdr = 1; cyc();
    chk(stat[6] == 1'b1 && irq_n == 1'b0, "R11", "unstrobed data ignored",
        {stat[6], irq_n}, 2'b10);

    tag = "R7";
    for (int i = 0; i < 3000; i++) begin
      ttx_hdr = ($urandom_range(3) == 0);
      ttx_clean = ttx_hdr && $urandom_range(1);
      vps_start = ($urandom_range(3) == 0);
      vps_clean = vps_start && $urandom_range(1);
      line = ($urandom_range(2) != 0);
      rd = ($urandom_range(3) == 0);
      ctrl_we = ($urandom_range(15) == 0); ctrl_wdata = 8'($urandom);
      ien_we = ($urandom_range(15) == 0); ien_wdata = 8'($urandom);
      cyc();
    end

    done = 1'b1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
    end
  end
endmodule